// File: doc/BRIEF.md
# External DMA Request Decoder

This block sits in front of a four-channel DMA engine and converts external transfer requests into one-cycle request pulses, one bit per channel. A request is signalled by a strobe. The strobe may come with a request word on the data bus, it may come alone, or it may come together with a direct-mode line. A request word carries a channel field, a mode field and a size field. A strobe that arrives alone re-targets the channel that was last served. A strobe with the direct-mode line targets channel 2 through a small occupancy-tracked queue.

Two sticky conditions stop the decoder. The first is an address error, which is raised by an illegal mode on a channel 0 word. The second is a freeze, which is raised by a channel 0 request made while the channel 0 transfer-end flag is set. Software releases either condition through a small flag interface. It must read the flag as 1 and then write 0 to it.

A small state machine sequences the decoder through three states: `ST_RUN`, `ST_HALT` and `ST_FROZEN`. Its transitions are:
- **run→halt** on an illegal mode.
- **run→frozen** on a channel 0 request while the transfer-end flag is set.
- **halt→run** when the error flag is cleared.
- **frozen→run** when the transfer-end flag is cleared.

Top module: `ext_dma_req_dec`

## Requirements
- R1: After synchronous reset, `ch_req` is 0, `q_full` is 0, both flags read 0, the decoder is in `ST_RUN`, and no channel is remembered as last served.
- R2: Request word layout: bits [1:0] are the channel, bits [3:2] the mode and bits [6:4] the size. When the strobe is sampled with `word_valid`=1 and a channel of 1, 2 or 3, `ch_req` shows only that channel's bit for exactly the cycle after the sampling edge, whatever the mode and size.
- R3: A channel 0 word with a non-zero mode sets the error flag (`reg_sel`=0) and moves the decoder to `ST_HALT`. No pulse is issued, and every strobe is dropped until the flag is cleared.
- R4: A flag clears only when a `reg_wr` with `reg_wdata`=0 follows a `reg_rd` that returned 1 for the same `reg_sel`. A write that has no such prior read leaves the flag at 1.
- R5: A channel 0 word with mode 0 is forwarded as a `ch_req[0]` pulse unless its size is 101 or 110. With either of those sizes the word is dropped silently: no pulse and no error.
- R6: A strobe with neither `word_valid` nor `direct_line` pulses the channel most recently forwarded.
- R7: A bare strobe that arrives before any request has been forwarded since reset is dropped.
- R8: The transfer-end flag (`reg_sel`=1) is set by `ch0_done`. A channel 0 request that is sampled while this flag is 1 moves the decoder to `ST_FROZEN` with no pulse. All strobes are then dropped until the flag is cleared as in R4.
- R9: A strobe with `direct_line` high takes priority over the word and pulses `ch_req[2]` when the channel 2 queue accepts it. The queue holds QDEPTH (4) entries, and `ch2_pop` removes one entry. A push at full is dropped unless a pop occurs in the same cycle. `q_full` is high exactly when the queue holds QDEPTH entries.
- R10: `bus_avail` is never asserted.
- R11: A channel 0 request sampled in the same cycle as `ch0_done` is judged against the flag value held before that edge, so it is forwarded, and the flag is set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_strobe | input | 1 | Transfer request strobe |
| word_valid | input | 1 | Request word present on `req_word` |
| req_word | input | 7 | Request word: size[6:4], mode[3:2], channel[1:0] |
| direct_line | input | 1 | Direct-mode request line (channel 2) |
| ch2_pop | input | 1 | Engine consumed one queued channel 2 request |
| ch0_done | input | 1 | Channel 0 transfer ended; sets the transfer-end flag |
| reg_rd | input | 1 | Flag read strobe |
| reg_wr | input | 1 | Flag write strobe |
| reg_sel | input | 1 | 0 selects the error flag, 1 selects the transfer-end flag |
| reg_wdata | input | 1 | Write data |
| reg_rdata | output | 1 | Value of the selected flag |
| ch_req | output | 4 | One-cycle per-channel request pulses |
| q_full | output | 1 | Channel 2 queue full |
| bus_avail | output | 1 | Bus-available indication, held low |

## Verification
Two pairs of events can collide in one cycle.

The first pair is a channel 0 request and the `ch0_done` event that sets its transfer-end flag. The bench drives both on the same edge. It expects the request to be forwarded, because the flag held before that edge is 0. It then expects the next channel 0 request to freeze the decoder.

The second pair is a direct-mode push and a queue pop while the queue is full. The bench drives that case and expects the push to be accepted with a `ch_req[2]` pulse while `q_full` stays high.

All 128 request words are swept, each followed by a bare strobe. The bench computes each expected pulse, or the error, from the word's fields.

// File: rtl/xdr_pkg.sv
package xdr_pkg;
    localparam int CH_N   = 4;
    localparam int CH_W   = 2;
    localparam int MODE_W = 2;
    localparam int SIZE_W = 3;
    localparam int WORD_W = CH_W + MODE_W + SIZE_W;
    localparam logic [SIZE_W-1:0] SIZE_BAD_A = 3'b101;
    localparam logic [SIZE_W-1:0] SIZE_BAD_B = 3'b110;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HALT   = 2'd1,
        ST_FROZEN = 2'd2
    } dec_state_e;

    typedef struct packed {
        logic [SIZE_W-1:0] size;
        logic [MODE_W-1:0] mode;
        logic [CH_W-1:0]   chan;
    } req_word_t;
endpackage

// File: rtl/xdr_field_decode.sv
module xdr_field_decode
    import xdr_pkg::*;
(
    input  req_word_t         word_i,
    output logic [CH_W-1:0]   chan_o,
    output logic              is_ch0_o,
    output logic              mode_bad_o,
    output logic              size_bad_o
);
    always_comb begin
        chan_o     = word_i.chan;
        is_ch0_o   = (word_i.chan == '0);
        mode_bad_o = is_ch0_o && (word_i.mode != '0);
        size_bad_o = is_ch0_o && ((word_i.size == SIZE_BAD_A) || (word_i.size == SIZE_BAD_B));
    end
endmodule

// File: rtl/xdr_ch2_queue.sv
module xdr_ch2_queue #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic push_i,
    input  logic pop_i,
    output logic accept_o,
    output logic full_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    logic [CNT_W-1:0] cnt_q;
    logic             pop_ok;

    assign pop_ok   = pop_i && (cnt_q != '0);
    assign full_o   = (cnt_q == CNT_MAX);
    assign accept_o = push_i && (!full_o || pop_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case ({accept_o, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_MAX); // R9
    AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (rst)
        (full_o && !pop_i) |=> (full_o && $stable(cnt_q))); // R9
endmodule

// File: rtl/xdr_sticky_flag.sv
module xdr_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wdata_i,
    output logic flag_o,
    output logic clr_evt_o
);
    logic armed_q;

    assign clr_evt_o = wr_i && armed_q && !wdata_i && flag_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (set_i)
                flag_o <= 1'b1;
            else if (clr_evt_o)
                flag_o <= 1'b0;
            if (wr_i)
                armed_q <= 1'b0;
            else if (rd_i && flag_o)
                armed_q <= 1'b1;
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr_evt_o) |=> flag_o); // R4
    AST_CLEAR_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
        (flag_o && wr_i && !armed_q) |=> flag_o); // R4
endmodule

// File: rtl/ext_dma_req_dec.sv
module ext_dma_req_dec
    import xdr_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_strobe,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] req_word,
    input  logic              direct_line,
    input  logic              ch2_pop,
    input  logic              ch0_done,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic              reg_wdata,
    output logic              reg_rdata,
    output logic [CH_N-1:0]   ch_req,
    output logic              q_full,
    output logic              bus_avail
);
    localparam logic [CH_W-1:0] DIRECT_CH = CH_W'(2);

    dec_state_e        state_q, state_n;
    logic [CH_W-1:0]   last_q, last_n;
    logic              last_valid_q, last_valid_n;
    logic [CH_N-1:0]   ch_req_n;

    logic [CH_W-1:0]   w_chan;
    logic              w_is_ch0, w_mode_bad, w_size_bad;
    logic              ae_flag, ae_clr, te_flag, te_clr;
    logic              q_accept;
    logic              running, direct_req, word_req, bare_req;
    logic              bad_mode_evt, cand0, freeze_evt;
    logic              fwd_ch2, fwd_word, fwd_bare;

    xdr_field_decode u_decode (
        .word_i     (req_word_t'(req_word)),
        .chan_o     (w_chan),
        .is_ch0_o   (w_is_ch0),
        .mode_bad_o (w_mode_bad),
        .size_bad_o (w_size_bad)
    );

    xdr_ch2_queue #(.DEPTH(QDEPTH)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .push_i   (direct_req),
        .pop_i    (ch2_pop),
        .accept_o (q_accept),
        .full_o   (q_full)
    );

    xdr_sticky_flag u_ae_flag (
        .clk       (clk),
        .rst       (rst),
        .set_i     (bad_mode_evt),
        .rd_i      (reg_rd && !reg_sel),
        .wr_i      (reg_wr && !reg_sel),
        .wdata_i   (reg_wdata),
        .flag_o    (ae_flag),
        .clr_evt_o (ae_clr)
    );

    xdr_sticky_flag u_te_flag (
        .clk       (clk),
        .rst       (rst),
        .set_i     (ch0_done),
        .rd_i      (reg_rd && reg_sel),
        .wr_i      (reg_wr && reg_sel),
        .wdata_i   (reg_wdata),
        .flag_o    (te_flag),
        .clr_evt_o (te_clr)
    );

    assign reg_rdata = reg_sel ? te_flag : ae_flag;
    assign bus_avail = 1'b0;
    assign ch_req_n  = '0 | ch_req_n_calc();

    // request classification
    always_comb begin
        running      = (state_q == ST_RUN);
        direct_req   = running && req_strobe && direct_line;
        word_req     = running && req_strobe && !direct_line && word_valid;
        bare_req     = running && req_strobe && !direct_line && !word_valid;
        bad_mode_evt = word_req && w_mode_bad;
        cand0        = (word_req && w_is_ch0 && !w_mode_bad && !w_size_bad)
                     || (bare_req && last_valid_q && (last_q == '0));
        freeze_evt   = cand0 && te_flag;
        fwd_ch2      = q_accept;
        fwd_word     = word_req && !w_mode_bad && !w_size_bad && !(w_is_ch0 && te_flag);
        fwd_bare     = bare_req && last_valid_q && !((last_q == '0) && te_flag);
    end

    function automatic logic [CH_N-1:0] ch_req_n_calc();
        logic [CH_N-1:0] v;
        v = '0;
        if (fwd_ch2)
            v[DIRECT_CH] = 1'b1;
        else if (fwd_word)
            v[w_chan] = 1'b1;
        else if (fwd_bare)
            v[last_q] = 1'b1;
        return v;
    endfunction

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (bad_mode_evt)
                    state_n = ST_HALT;
                else if (freeze_evt)
                    state_n = ST_FROZEN;
            end
            ST_HALT: begin
                if (ae_clr)
                    state_n = ST_RUN;
            end
            ST_FROZEN: begin
                if (te_clr)
                    state_n = ST_RUN;
            end
            default: state_n = ST_RUN;
        endcase
    end

    // outputs and last-channel tracking
    always_comb begin
        last_n       = last_q;
        last_valid_n = last_valid_q;
        if (fwd_ch2) begin
            last_n       = DIRECT_CH;
            last_valid_n = 1'b1;
        end else if (fwd_word) begin
            last_n       = w_chan;
            last_valid_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_RUN;
            last_q       <= '0;
            last_valid_q <= 1'b0;
            ch_req       <= '0;
        end else begin
            state_q      <= state_n;
            last_q       <= last_n;
            last_valid_q <= last_valid_n;
            ch_req       <= ch_req_n;
        end
    end

    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_req)); // R2
    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_RUN) |=> (ch_req == '0)); // R3
    AST_BAD_MODE_HALTS: assert property (@(posedge clk) disable iff (rst)
        bad_mode_evt |=> (state_q == ST_HALT)); // R3
    AST_FIRST_BARE_DROP: assert property (@(posedge clk) disable iff (rst)
        (req_strobe && !direct_line && !word_valid && !last_valid_q) |=> (ch_req == '0)); // R7
    AST_FREEZE_ENTRY: assert property (@(posedge clk) disable iff (rst)
        freeze_evt |=> (state_q == ST_FROZEN && ch_req == '0)); // R8
    AST_NO_BUS_AVAIL: assert property (@(posedge clk) disable iff (rst)
        req_strobe |=> !bus_avail); // R10
endmodule

// File: tb/ext_dma_req_dec_tb.sv
module ext_dma_req_dec_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_strobe = 1'b0, word_valid = 1'b0, direct_line = 1'b0;
    logic [6:0] req_word = '0;
    logic       ch2_pop = 1'b0, ch0_done = 1'b0;
    logic       reg_rd = 1'b0, reg_wr = 1'b0, reg_sel = 1'b0, reg_wdata = 1'b0;
    logic       reg_rdata, q_full, bus_avail;
    logic [3:0] ch_req;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit ba_seen = 0;
    logic [3:0] o_req;
    logic       o_full, o_rd;

    always #5 clk = ~clk;

    ext_dma_req_dec #(.QDEPTH(4)) u_dut (
        .clk(clk), .rst(rst), .req_strobe(req_strobe), .word_valid(word_valid),
        .req_word(req_word), .direct_line(direct_line), .ch2_pop(ch2_pop),
        .ch0_done(ch0_done), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_req(ch_req),
        .q_full(q_full), .bus_avail(bus_avail)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic s, input logic wv, input logic [6:0] w, input logic dl,
                        input logic pop, input logic done, input logic rd, input logic wr,
                        input logic sel, input logic wd);
        @(negedge clk);
        req_strobe = s; word_valid = wv; req_word = w; direct_line = dl;
        ch2_pop = pop; ch0_done = done; reg_rd = rd; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        @(posedge clk);
        #1;
        o_req = ch_req; o_full = q_full; o_rd = reg_rdata;
        if (bus_avail !== 1'b0) ba_seen = 1;
    endtask

    task automatic idle();
        step(0, 0, 7'h00, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic send_word(input logic [6:0] w, input logic done);
        step(1, 1, w, 0, 0, done, 0, 0, 0, 0);
    endtask
    task automatic send_bare();
        step(1, 0, 7'h00, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic rd_flag(input logic sel);
        step(0, 0, 7'h00, 0, 0, 0, 1, 0, sel, 0);
    endtask
    task automatic wr_flag(input logic sel, input logic wd);
        step(0, 0, 7'h00, 0, 0, 0, 0, 1, sel, wd);
    endtask
    task automatic direct(input logic pop, input logic wv, input logic [6:0] w);
        step(1, wv, w, 1, pop, 0, 0, 0, 0, 0);
    endtask
    task automatic pop_only();
        step(0, 0, 7'h00, 0, 1, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [1:0] last_ch;
        bit         last_v;
        bit         r4_done;
        last_ch = 2'd0; last_v = 0; r4_done = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle();
        // R1 reset state
        chk("R1 ch_req", {4'h0, o_req}, 8'h0);
        chk("R1 q_full", {7'h0, o_full}, 8'h0);
        rd_flag(0);
        chk("R1 error flag", {7'h0, o_rd}, 8'h0);
        rd_flag(1);
        chk("R1 end flag", {7'h0, o_rd}, 8'h0);

        // R7 first bare strobe after reset dropped
        send_bare();
        chk("R7 first bare", {4'h0, o_req}, 8'h0);

        // sweep all request words, each followed by a bare strobe
        for (int w = 0; w < 128; w++) begin
            logic [6:0] wv;
            logic [1:0] chn, md;
            logic [2:0] sz;
            wv = w[6:0];
            chn = wv[1:0]; md = wv[3:2]; sz = wv[6:4];
            send_word(wv, 0);
            if (chn == 2'd0 && md != 2'd0) begin
                chk("R3 no pulse on bad mode", {4'h0, o_req}, 8'h0);
                rd_flag(0);
                chk("R3 error flag set", {7'h0, o_rd}, 8'h1);
                send_word(7'h01, 0);
                chk("R3 halted drops request", {4'h0, o_req}, 8'h0);
                if (!r4_done) begin
                    r4_done = 1;
                    wr_flag(0, 0);  // armed by the read above: clears
                    rd_flag(0);
                    chk("R4 read-then-write clears", {7'h0, o_rd}, 8'h0);
                    send_word(wv, 0);
                    wr_flag(0, 0);  // write with no prior read
                    rd_flag(0);
                    chk("R4 write without read keeps flag", {7'h0, o_rd}, 8'h1);
                end
                wr_flag(0, 0);
                rd_flag(0);
                chk("R4 flag cleared", {7'h0, o_rd}, 8'h0);
            end else if (chn == 2'd0 && (sz == 3'd5 || sz == 3'd6)) begin
                chk("R5 bad size dropped", {4'h0, o_req}, 8'h0);
            end else begin
                chk(chn == 2'd0 ? "R5 ch0 forwarded" : "R2 word forwarded",
                    {4'h0, o_req}, 8'(4'b0001 << chn));
                last_ch = chn; last_v = 1;
            end
            idle();
            chk("R2 pulse lasts one cycle", {4'h0, o_req}, 8'h0);
            send_bare();
            chk("R6 bare targets last", {4'h0, o_req}, last_v ? 8'(4'b0001 << last_ch) : 8'h0);
        end

        // R11 same-cycle ch0 request and ch0_done
        send_word(7'h00, 1);
        chk("R11 ch0 with done forwarded", {4'h0, o_req}, 8'h1);
        // R8 freeze
        send_word(7'h00, 0);
        chk("R8 ch0 with end flag frozen", {4'h0, o_req}, 8'h0);
        send_word(7'h02, 0);
        chk("R8 frozen drops ch2 word", {4'h0, o_req}, 8'h0);
        rd_flag(1);
        chk("R11 end flag set", {7'h0, o_rd}, 8'h1);
        wr_flag(1, 0);
        rd_flag(1);
        chk("R8 end flag cleared", {7'h0, o_rd}, 8'h0);
        send_word(7'h00, 0);
        chk("R8 resumed ch0", {4'h0, o_req}, 8'h1);

        // R9 direct mode queue
        for (int i = 0; i < 4; i++) begin
            direct(0, 0, 7'h00);
            chk("R9 direct push pulse", {4'h0, o_req}, 8'h4);
            chk("R9 full flag", {7'h0, o_full}, {7'h0, (i == 3)});
        end
        direct(0, 0, 7'h00);
        chk("R9 push at full dropped", {4'h0, o_req}, 8'h0);
        chk("R9 still full", {7'h0, o_full}, 8'h1);
        direct(1, 0, 7'h00);
        chk("R9 push with pop at full", {4'h0, o_req}, 8'h4);
        chk("R9 full after push+pop", {7'h0, o_full}, 8'h1);
        pop_only();
        chk("R9 pop clears full", {7'h0, o_full}, 8'h0);
        direct(0, 1, 7'h01);
        chk("R9 direct over word", {4'h0, o_req}, 8'h4);
        chk("R9 full again", {7'h0, o_full}, 8'h1);
        send_bare();
        chk("R6 bare after direct", {4'h0, o_req}, 8'h4);
        for (int i = 0; i < 5; i++) pop_only();
        chk("R9 empty not full", {7'h0, o_full}, 8'h0);
        direct(0, 0, 7'h00);
        chk("R9 push after drain", {4'h0, o_req}, 8'h4);
        idle();

        chk("R10 bus_avail never high", {7'h0, ba_seen}, 8'h0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule